// File: doc/BRIEF.md
# Cascaded DMA Request Arbiter

This block chooses which DMA channel owns the transfer bus. Eight channel numbers are split across two four-channel controllers. The primary controller holds channels 0–3. The secondary controller holds channels 5–7. Channel 4 is reserved as the link through which the secondary controller's winner reaches the primary one. A channel can ask for service in two ways: through its hardware request line, or through a bit that software sets in a request register. Both kinds of request are treated alike. Each channel also has a mask bit that hides its requests.

Each controller resolves its own requests by fixed priority, where the lowest number wins. The secondary controller as a whole competes at the cascade slot, so it ranks below channels 0–3. The chosen channel receives a registered one-hot acknowledge, its channel number and a valid flag. It keeps the grant until its own request goes away. A terminal-count pulse clears the software request bit of the channel currently being served.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, no acknowledge, grant number or valid flag is asserted, every software request bit reads 0 and every mask bit is set (all channels masked).
- R2: At most one bit of `ack` is ever set. Bit n of `ack` stands for channel n. When `grant_valid` is 1, `grant_chan` equals n; when it is 0, `grant_chan` is 0.
- R3: Channel 4 is never acknowledged. Its hardware request line is ignored, and a software write to channel 4 leaves bit 4 of `sw_pend` at 0.
- R4: A software write with `sw_wr_en`=1 sets bit `sw_wr_chan` of `sw_pend` to `sw_wr_val` one clock later. A set bit then counts as a request exactly as a hardware request would.
- R5: A mask write sets mask bit `mask_wr_chan` to `mask_wr_val` one clock later (1 = masked). A masked channel's hardware and software requests are both ignored.
- R6: Among requesting channels 0–3, the lowest channel number is granted.
- R7: Any unmasked request on channels 0–3 beats every request on channels 5–7. Among channels 5–7, the lowest channel number wins.
- R8: While mask bit 4 is set, none of channels 5–7 can be granted.
- R9: A granted channel keeps the grant for as long as its own unmasked request stays present, even if a higher-priority request arrives.
- R10: A grant appears on the clock edge that samples the request. When the granted request drops, the next edge either passes the grant to the current winner or clears it.
- R11: A `tc` pulse during a grant clears that channel's software request bit on the next edge. A software write to the same channel in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 8 | Hardware request line per channel (bit 4 ignored) |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_chan | input | 3 | Channel whose software request bit is written |
| sw_wr_val | input | 1 | Value written to that software request bit |
| mask_wr_en | input | 1 | Write strobe for the mask register |
| mask_wr_chan | input | 3 | Channel whose mask bit is written |
| mask_wr_val | input | 1 | Mask value written (1 = masked) |
| tc | input | 1 | Terminal count of the channel being served |
| ack | output | 8 | One-hot acknowledge to the granted channel |
| grant_chan | output | 3 | Number of the granted channel |
| grant_valid | output | 1 | A grant is active |
| sw_pend | output | 8 | Current software request bits |

## Verification
Directed patterns target specific rules:
- Requests among channels 0–3 only check the priority inside the primary controller.
- A mix of primary and secondary requests shows whether the cascade slot ranks below channel 3.
- A late higher-priority request arriving on top of a grant that is in service separates hold behaviour from pre-emption.
- Patterns that mask the cascade channel, or request channel 4 directly, confirm that the link channel never reaches a device.

A long constrained-random run then mixes sparse hardware requests, software writes, mask writes and terminal-count pulses. Every cycle is compared with a bench model, which exposes ordering bugs between a terminal-count clear and a software write in the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CH_PER_CTRL = 4;
  localparam int NUM_CTRL    = 2;
  localparam int NUM_CH      = CH_PER_CTRL * NUM_CTRL;
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int LOC_W       = $clog2(CH_PER_CTRL);
  localparam int LINK_CH     = CH_PER_CTRL;

  // one-hot decode of a channel number, gated by a valid flag
  function automatic logic [NUM_CH-1:0] chan_onehot(input logic v, input logic [CH_W-1:0] c);
    logic [NUM_CH-1:0] r;
    r = '0;
    if (v) r[c] = 1'b1;
    return r;
  endfunction

  // request a channel presents after masking; the link channel never requests
  // on its own, secondary channels also need the link channel unmasked
  function automatic logic [NUM_CH-1:0] live_requests(input logic [NUM_CH-1:0] hw,
                                                      input logic [NUM_CH-1:0] sw,
                                                      input logic [NUM_CH-1:0] msk);
    logic [NUM_CH-1:0] r;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c == LINK_CH)      r[c] = 1'b0;
      else if (c < LINK_CH)  r[c] = (hw[c] | sw[c]) & ~msk[c];
      else                   r[c] = (hw[c] | sw[c]) & ~msk[c] & ~msk[LINK_CH];
    end
    return r;
  endfunction
endpackage

// File: rtl/dma_prio_enc.sv
module dma_prio_enc #(
  parameter int W = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index wins: scan from the top so the last hit is the lowest
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_req_regs.sv
module dma_req_regs
  import dma_arb_pkg::*;
#(
  parameter int N    = NUM_CH,
  parameter int LINK = LINK_CH,
  localparam int CW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_wr_en,
  input  logic [CW-1:0] sw_wr_chan,
  input  logic          sw_wr_val,
  input  logic          mask_wr_en,
  input  logic [CW-1:0] mask_wr_chan,
  input  logic          mask_wr_val,
  input  logic          tc_clr_en,
  input  logic [CW-1:0] tc_clr_chan,
  output logic [N-1:0]  sw_q,
  output logic [N-1:0]  mask_q
);
  logic [N-1:0] sw_nxt;
  logic         sw_write_ok;

  assign sw_write_ok = sw_wr_en && (sw_wr_chan != CW'(LINK));

  always_comb begin
    sw_nxt = sw_q;
    if (tc_clr_en)   sw_nxt[tc_clr_chan] = 1'b0;
    if (sw_write_ok) sw_nxt[sw_wr_chan]  = sw_wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      mask_q <= '1;
    end else begin
      sw_q <= sw_nxt;
      if (mask_wr_en) mask_q[mask_wr_chan] <= mask_wr_val;
    end
  end

  // R3: link channel software bit never becomes set
  a_r3_link_sw_zero: assert property (@(posedge clk) disable iff (!rst_n) !sw_q[LINK]);
  // R11: terminal count clears the served channel's bit unless rewritten
  a_r11_tc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr_en && !(sw_wr_en && sw_wr_chan == tc_clr_chan)) |=> !sw_q[$past(tc_clr_chan)]);
  // R4: a legal write lands one clock later
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    sw_write_ok |=> sw_q[$past(sw_wr_chan)] == $past(sw_wr_val));
  // R5: mask writes land one clock later
  a_r5_mask_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> mask_q[$past(mask_wr_chan)] == $past(mask_wr_val));
endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl
  import dma_arb_pkg::*;
#(
  parameter int N   = NUM_CH,
  localparam int CW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  live_req,
  input  logic          win_any,
  input  logic [CW-1:0] win_idx,
  output logic          valid_q,
  output logic [CW-1:0] idx_q,
  output logic [N-1:0]  ack,
  output logic          keep_grant,
  output logic          take_new
);
  assign keep_grant = valid_q && live_req[idx_q];
  assign take_new   = !keep_grant && win_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else if (!keep_grant) begin
      valid_q <= win_any;
      idx_q   <= win_any ? win_idx : '0;
    end
  end

  always_comb begin
    ack = '0;
    if (valid_q) ack[idx_q] = 1'b1;
  end

  // R2: never two acknowledges
  a_r2_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ack));
  // R9: a held grant keeps its channel
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    keep_grant |=> (valid_q && idx_q == $past(idx_q)));
  // R10: a new winner is registered on the next edge
  a_r10_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_new |=> (valid_q && idx_q == $past(win_idx)));
  // R10: no request left releases the grant
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!keep_grant && !win_any) |=> !valid_q);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hw_req,
  input  logic              sw_wr_en,
  input  logic [CH_W-1:0]   sw_wr_chan,
  input  logic              sw_wr_val,
  input  logic              mask_wr_en,
  input  logic [CH_W-1:0]   mask_wr_chan,
  input  logic              mask_wr_val,
  input  logic              tc,
  output logic [NUM_CH-1:0] ack,
  output logic [CH_W-1:0]   grant_chan,
  output logic              grant_valid,
  output logic [NUM_CH-1:0] sw_pend
);
  logic [NUM_CH-1:0]   mask_q;
  logic [NUM_CH-1:0]   live_req;
  logic [NUM_CTRL-1:0] ctrl_any;
  logic [LOC_W-1:0]    ctrl_idx [NUM_CTRL];
  logic                win_any;
  logic [CH_W-1:0]     win_idx;
  logic                keep_grant;
  logic                take_new;

  dma_req_regs #(.N(NUM_CH), .LINK(LINK_CH)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_chan   (sw_wr_chan),
    .sw_wr_val    (sw_wr_val),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_chan (mask_wr_chan),
    .mask_wr_val  (mask_wr_val),
    .tc_clr_en    (tc && grant_valid),
    .tc_clr_chan  (grant_chan),
    .sw_q         (sw_pend),
    .mask_q       (mask_q)
  );

  assign live_req = live_requests(hw_req, sw_pend, mask_q);

  // one fixed-priority encoder per controller
  for (genvar k = 0; k < NUM_CTRL; k++) begin : g_ctrl
    dma_prio_enc #(.W(CH_PER_CTRL)) u_enc (
      .req (live_req[k*CH_PER_CTRL +: CH_PER_CTRL]),
      .any (ctrl_any[k]),
      .idx (ctrl_idx[k])
    );
  end

  // secondary result enters the primary at the link slot, after channel 3
  assign win_any = ctrl_any[0] | ctrl_any[1];
  assign win_idx = ctrl_any[0] ? {1'b0, ctrl_idx[0]} : {1'b1, ctrl_idx[1]};

  dma_grant_ctrl #(.N(NUM_CH)) u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .live_req   (live_req),
    .win_any    (win_any),
    .win_idx    (win_idx),
    .valid_q    (grant_valid),
    .idx_q      (grant_chan),
    .ack        (ack),
    .keep_grant (keep_grant),
    .take_new   (take_new)
  );

  // R3: the link channel never reaches a device
  a_r3_no_link_ack: assert property (@(posedge clk) disable iff (!rst_n) !ack[LINK_CH]);
  // R7: a primary request keeps the winner inside channels 0-3
  a_r7_primary_first: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_any[0] |-> win_idx < CH_W'(LINK_CH));
  // R8: masking the link channel silences the secondary controller
  a_r8_link_mask: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[LINK_CH] |-> !ctrl_any[1]);
  // R5: a new grant only goes to an unmasked channel
  a_r5_unmasked_winner: assert property (@(posedge clk) disable iff (!rst_n)
    take_new |-> !mask_q[win_idx]);
  // R2: the number matches the acknowledge
  a_r2_chan_matches: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> ack[grant_chan]);
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] hw_req = '0;
  logic       sw_wr_en = 1'b0, sw_wr_val = 1'b0, mask_wr_en = 1'b0, mask_wr_val = 1'b0, tc = 1'b0;
  logic [2:0] sw_wr_chan = '0, mask_wr_chan = '0;
  logic [7:0] ack, sw_pend;
  logic [2:0] grant_chan;
  logic       grant_valid;

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // bench model state
  logic [7:0] m_sw = '0, m_mask = '1;
  logic       m_valid = 1'b0;
  logic [2:0] m_idx = '0;

  always #5 clk = ~clk;

  dma_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .sw_wr_en(sw_wr_en), .sw_wr_chan(sw_wr_chan), .sw_wr_val(sw_wr_val),
    .mask_wr_en(mask_wr_en), .mask_wr_chan(mask_wr_chan), .mask_wr_val(mask_wr_val),
    .tc(tc), .ack(ack), .grant_chan(grant_chan), .grant_valid(grant_valid), .sw_pend(sw_pend)
  );

  // request seen by arbitration, written as a priority-ordered list walk
  function automatic logic [7:0] m_live(input logic [7:0] hw, input logic [7:0] sw, input logic [7:0] mk);
    logic [7:0] r = '0;
    for (int c = 0; c < 8; c++)
      if (c != 4 && (hw[c] || sw[c]) && !mk[c] && !(c > 4 && mk[4])) r[c] = 1'b1;
    return r;
  endfunction

  function automatic int m_pick(input logic [7:0] live);
    int order [7] = '{0, 1, 2, 3, 5, 6, 7};
    foreach (order[i]) if (live[order[i]]) return order[i];
    return -1;
  endfunction

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic compare_all();
    check({tag, " ack"}, 32'(ack), m_valid ? 32'(1) << m_idx : 32'd0);
    check({tag, " valid"}, 32'(grant_valid), 32'(m_valid));
    check({tag, " chan"}, 32'(grant_chan), m_valid ? 32'(m_idx) : 32'd0);
    check({tag, " sw_pend"}, 32'(sw_pend), 32'(m_sw));
  endtask

  task automatic step(input logic [7:0] hw, input logic swe, input logic [2:0] swc, input logic swv,
                      input logic me, input logic [2:0] mc, input logic mv, input logic t);
    logic [7:0] live;
    int p;
    hw_req = hw; sw_wr_en = swe; sw_wr_chan = swc; sw_wr_val = swv;
    mask_wr_en = me; mask_wr_chan = mc; mask_wr_val = mv; tc = t;
    live = m_live(hw, m_sw, m_mask);
    if (t && m_valid) m_sw[m_idx] = 1'b0;
    if (swe && swc != 3'd4) m_sw[swc] = swv;
    if (me) m_mask[mc] = mv;
    if (!(m_valid && live[m_idx])) begin
      p = m_pick(live);
      m_valid = (p >= 0);
      m_idx = (p >= 0) ? 3'(p) : 3'd0;
    end
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic hw_only(input logic [7:0] hw);
    step(hw, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] rh;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    hw_only(8'hFF);
    check("R1 all masked after reset", 32'(grant_valid), 0);
    hw_only(8'h00);
    // R5 unmask every channel
    tag = "R5";
    for (int c = 0; c < 8; c++) step(0, 0, 0, 0, 1, 3'(c), 0, 0);
    // R6 priority inside primary
    tag = "R6";
    hw_only(8'b0000_1110);
    check("R6 lowest of 1..3", 32'(grant_chan), 1);
    hw_only(8'h00);
    hw_only(8'b0000_1100);
    check("R6 lowest of 2..3", 32'(grant_chan), 2);
    hw_only(8'h00);
    // R7 cascade slot below channel 3
    tag = "R7";
    hw_only(8'hE8);
    check("R7 ch3 beats secondary", 32'(grant_chan), 3);
    hw_only(8'h00);
    hw_only(8'hE0);
    check("R7 ch5 lowest secondary", 32'(grant_chan), 5);
    hw_only(8'h00);
    // R9 hold, R10 release and switch
    tag = "R9";
    hw_only(8'h40);
    check("R9 ch6 granted", 32'(ack), 32'h40);
    hw_only(8'h41);
    check("R9 no pre-emption by ch0", 32'(grant_chan), 6);
    tag = "R10";
    hw_only(8'h01);
    check("R10 switch to ch0 after drop", 32'(grant_chan), 0);
    hw_only(8'h00);
    check("R10 release", 32'(grant_valid), 0);
    // R3 link channel
    tag = "R3";
    hw_only(8'h10);
    check("R3 ch4 hw ignored", 32'(grant_valid), 0);
    step(0, 1, 3'd4, 1, 0, 0, 0, 0);
    check("R3 sw bit4 stays 0", 32'(sw_pend[4]), 0);
    hw_only(8'h00);
    check("R3 no ack on link", 32'(ack[4]), 0);
    // R8 link mask blocks 5..7; R5 mask on own channel
    tag = "R8";
    step(0, 0, 0, 0, 1, 3'd4, 1, 0);
    hw_only(8'hE0);
    check("R8 secondary blocked", 32'(grant_valid), 0);
    hw_only(8'hE1);
    check("R8 primary still served", 32'(grant_chan), 0);
    hw_only(8'h00);
    step(0, 0, 0, 0, 1, 3'd4, 0, 0);
    tag = "R5";
    step(0, 0, 0, 0, 1, 3'd1, 1, 0);
    hw_only(8'h06);
    check("R5 masked ch1 skipped", 32'(grant_chan), 2);
    hw_only(8'h00);
    step(0, 0, 0, 0, 1, 3'd1, 0, 0);
    // R4 software request, R11 terminal count
    tag = "R4";
    step(0, 1, 3'd2, 1, 0, 0, 0, 0);
    check("R4 sw bit2 set", 32'(sw_pend), 32'h04);
    hw_only(8'h00);
    check("R4 sw request granted", 32'(grant_chan), 2);
    tag = "R11";
    step(0, 0, 0, 0, 0, 0, 0, 1);
    check("R11 tc clears sw bit2", 32'(sw_pend), 0);
    hw_only(8'h00);
    check("R11 grant released", 32'(grant_valid), 0);
    step(0, 1, 3'd7, 1, 0, 0, 0, 0);
    hw_only(8'h00);
    step(0, 1, 3'd7, 1, 0, 0, 0, 1);
    check("R11 same-cycle write wins", 32'(sw_pend[7]), 1);
    step(0, 1, 3'd7, 0, 0, 0, 0, 0);
    // R2 random mix
    tag = "R2";
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      rh = 8'($urandom) & 8'($urandom) & 8'($urandom);
      step(rh, ($urandom % 6) == 0, 3'($urandom), 1'($urandom),
           ($urandom % 10) == 0, 3'($urandom), ($urandom % 3) == 0, ($urandom % 5) == 0);
      check("R2 onehot ack", 32'($countones(ack) <= 1), 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule